// File: doc/BRIEF.md
# Scalar Register File with Zero-Register Aliasing

This block holds the general-purpose integer state of a 64-bit load/store core: thirty-one general registers plus a stack-pointer register, read through two independent combinational ports and written through one clocked port. Every access carries a five-bit index and a per-access selector. When the selector is set, index 31 reaches the stored stack pointer. When it is clear, index 31 names a hard-wired zero: reads return zero and writes are dropped.

Reads can return the whole register or only its low 32, 16 or 8 bits, widened back to 64 bits with zeros or with copies of the slice's top bit. Writes are either full-width or 32-bit. A 32-bit write clears the upper half of its destination. A separate link-save input stores a return address into register 30 in the same clock edge as an ordinary write. If both target register 30, the ordinary write wins.

Top module: `scalar_regfile`

## Requirements
- R1: A read of index 31 with the stack-pointer selector low returns all zeros at every read width, whatever the stored stack pointer holds.
- R2: A write to index 31 with the stack-pointer selector low changes no stored register, including the stack pointer.
- R3: With the selector high, index 31 reads and writes a stored 64-bit stack-pointer register.
- R4: A 32-bit write (`wr_narrow`=1) stores data bits 31:0 in bits 31:0 of the destination and forces bits 63:32 to zero.
- R5: Read width code 1, 2 or 3 (32, 16 or 8 bits) with `sext`=0 returns the low slice with zeros above it.
- R6: The same width codes with `sext`=1 return the low slice with its top bit copied into every higher bit.
- R7: Width code 0 returns all 64 stored bits, and a full-width write stores all 64 data bits.
- R8: With `lk_en` high, register 30 takes `lk_addr` at the next rising edge.
- R9: If a link save and an ordinary write to register 30 occur in the same cycle, register 30 takes the ordinary write data.
- R10: Reads are combinational from stored state. A read of the register being written in the same cycle returns the old value, and the new value appears only after the edge.
- R11: While synchronous reset `rst` is high at a rising edge, all 32 stored registers become zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ra_idx | input | 5 | Read port A register index |
| ra_sp | input | 1 | Port A: index 31 means stack pointer when high, zero when low |
| ra_size | input | 2 | Port A width: 0=64, 1=32, 2=16, 3=8 bits |
| ra_sext | input | 1 | Port A: 1 sign-extends a narrow slice, 0 zero-extends it |
| ra_data | output | 64 | Port A read data |
| rb_idx | input | 5 | Read port B register index |
| rb_sp | input | 1 | Port B stack-pointer selector |
| rb_size | input | 2 | Port B width code, same encoding as port A |
| rb_sext | input | 1 | Port B extension select |
| rb_data | output | 64 | Port B read data |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Write destination index |
| wr_sp | input | 1 | Write stack-pointer selector |
| wr_narrow | input | 1 | 1 = 32-bit write with upper half cleared, 0 = 64-bit write |
| wr_data | input | 64 | Write data |
| lk_en | input | 1 | Link-save enable |
| lk_addr | input | 64 | Return address to store in register 30 |

## Verification
The bench first loads a different pattern into every index. Half of the patterns have their slice top bits set, so every width and extension mode is checked against expected values computed arithmetically. A design that ignored the sign bit, or used the wrong slice boundary, would return wrong upper bits for those patterns.

Index 31 is then read and written with the selector low while the stack pointer holds a nonzero value. A design that aliased the zero register onto the stack pointer would leak that value or overwrite it.

The bench also probes:
- 32-bit writes whose data has ones in the upper half. A design that kept or copied those upper bits would fail.
- A link save colliding with an ordinary write to register 30. A design with the wrong priority would store the return address instead.
- A read taken in the same cycle as the write to that register. A design with a bypass would show the new value early.

// File: rtl/gpr_pkg.sv
package gpr_pkg;

    localparam int XLEN     = 64;
    localparam int NREG     = 32;
    localparam int IDXW     = $clog2(NREG);
    localparam int HALFW    = XLEN / 2;
    localparam int ALIAS_IX = NREG - 1;

    typedef enum logic [1:0] {
        SZ_FULL = 2'd0,
        SZ_WORD = 2'd1,
        SZ_HALF = 2'd2,
        SZ_BYTE = 2'd3
    } size_e;

    typedef struct packed {
        logic [IDXW-1:0] idx;
        logic            sp;
        size_e           size;
        logic            sext;
    } rd_req_t;

    typedef struct packed {
        logic            en;
        logic [IDXW-1:0] idx;
        logic [XLEN-1:0] data;
    } wr_op_t;

    function automatic logic hits_zero(input logic [IDXW-1:0] idx, input logic sp);
        return (idx == IDXW'(ALIAS_IX)) && !sp;
    endfunction

endpackage

// File: rtl/gpr_rd_port.sv
module gpr_rd_port
    import gpr_pkg::*;
(
    input  logic [NREG-1:0][XLEN-1:0] regs,
    input  rd_req_t                   req,
    output logic [XLEN-1:0]           data
);

    logic [XLEN-1:0] raw;

    always_comb begin
        raw = hits_zero(req.idx, req.sp) ? '0 : regs[req.idx];
        unique case (req.size)
            SZ_WORD: data = req.sext ? {{(XLEN-32){raw[31]}}, raw[31:0]}
                                     : {{(XLEN-32){1'b0}},   raw[31:0]};
            SZ_HALF: data = req.sext ? {{(XLEN-16){raw[15]}}, raw[15:0]}
                                     : {{(XLEN-16){1'b0}},   raw[15:0]};
            SZ_BYTE: data = req.sext ? {{(XLEN-8){raw[7]}}, raw[7:0]}
                                     : {{(XLEN-8){1'b0}},   raw[7:0]};
            default: data = raw;
        endcase
    end

endmodule

// File: rtl/gpr_wr_shape.sv
module gpr_wr_shape
    import gpr_pkg::*;
#(
    parameter int LINK_IX = 30
) (
    input  logic            wr_en,
    input  logic [IDXW-1:0] wr_idx,
    input  logic            wr_sp,
    input  logic            wr_narrow,
    input  logic [XLEN-1:0] wr_data,
    input  logic            lk_en,
    input  logic [XLEN-1:0] lk_addr,
    output wr_op_t          main_op,
    output wr_op_t          link_op
);

    always_comb begin
        main_op.en   = wr_en && !hits_zero(wr_idx, wr_sp);
        main_op.idx  = wr_idx;
        main_op.data = wr_narrow ? {{HALFW{1'b0}}, wr_data[HALFW-1:0]} : wr_data;

        link_op.en   = lk_en && !(main_op.en && (wr_idx == IDXW'(LINK_IX)));
        link_op.idx  = IDXW'(LINK_IX);
        link_op.data = lk_addr;
    end

endmodule

// File: rtl/gpr_store.sv
module gpr_store
    import gpr_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  wr_op_t                    main_op,
    input  wr_op_t                    link_op,
    output logic [NREG-1:0][XLEN-1:0] regs_q
);

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs_q[g] <= '0;
            end else if (main_op.en && main_op.idx == IDXW'(g)) begin
                regs_q[g] <= main_op.data;
            end else if (link_op.en && link_op.idx == IDXW'(g)) begin
                regs_q[g] <= link_op.data;
            end
        end
    end

endmodule

// File: rtl/scalar_regfile.sv
module scalar_regfile
    import gpr_pkg::*;
#(
    parameter int LINK_IX = 30
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [4:0]      ra_idx,
    input  logic            ra_sp,
    input  logic [1:0]      ra_size,
    input  logic            ra_sext,
    output logic [63:0]     ra_data,
    input  logic [4:0]      rb_idx,
    input  logic            rb_sp,
    input  logic [1:0]      rb_size,
    input  logic            rb_sext,
    output logic [63:0]     rb_data,
    input  logic            wr_en,
    input  logic [4:0]      wr_idx,
    input  logic            wr_sp,
    input  logic            wr_narrow,
    input  logic [63:0]     wr_data,
    input  logic            lk_en,
    input  logic [63:0]     lk_addr
);

    localparam int NPORT = 2;

    logic [NREG-1:0][XLEN-1:0] regs_q;
    wr_op_t                    main_op;
    wr_op_t                    link_op;
    rd_req_t [NPORT-1:0]       req;
    logic [NPORT-1:0][XLEN-1:0] rdata;

    always_comb begin
        req[0] = '{idx: ra_idx, sp: ra_sp, size: size_e'(ra_size), sext: ra_sext};
        req[1] = '{idx: rb_idx, sp: rb_sp, size: size_e'(rb_size), sext: rb_sext};
    end

    gpr_wr_shape #(.LINK_IX(LINK_IX)) u_shape (
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_sp     (wr_sp),
        .wr_narrow (wr_narrow),
        .wr_data   (wr_data),
        .lk_en     (lk_en),
        .lk_addr   (lk_addr),
        .main_op   (main_op),
        .link_op   (link_op)
    );

    gpr_store u_store (
        .clk     (clk),
        .rst     (rst),
        .main_op (main_op),
        .link_op (link_op),
        .regs_q  (regs_q)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_rd
        gpr_rd_port u_rd (
            .regs (regs_q),
            .req  (req[p]),
            .data (rdata[p])
        );
    end

    assign ra_data = rdata[0];
    assign rb_data = rdata[1];

endmodule

// File: rtl/scalar_regfile_chk.sv
module scalar_regfile_chk
    import gpr_pkg::*;
#(
    parameter int LINK_IX = 30
) (
    input logic                      clk,
    input logic                      rst,
    input logic [4:0]                ra_idx,
    input logic                      ra_sp,
    input logic [63:0]               ra_data,
    input logic                      wr_en,
    input logic [4:0]                wr_idx,
    input logic                      wr_sp,
    input logic                      wr_narrow,
    input logic [63:0]               wr_data,
    input logic                      lk_en,
    input logic [63:0]               lk_addr,
    input logic [NREG-1:0][XLEN-1:0] regs
);

    // R1
    p_zero_read_r1: assert property (@(posedge clk) disable iff (rst)
        (ra_idx == 5'(ALIAS_IX) && !ra_sp) |-> ra_data == '0);

    // R2
    p_drop_zero_write_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx == 5'(ALIAS_IX) && !wr_sp && !lk_en) |=> $stable(regs));

    // R4
    p_narrow_clears_upper_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_narrow && wr_idx == 5'(ALIAS_IX) && wr_sp)
        |=> regs[ALIAS_IX][XLEN-1:HALFW] == '0);

    // R8
    p_link_save_r8: assert property (@(posedge clk) disable iff (rst)
        (lk_en && !(wr_en && wr_idx == 5'(LINK_IX)))
        |=> regs[LINK_IX] == $past(lk_addr));

    // R9
    p_write_beats_link_r9: assert property (@(posedge clk) disable iff (rst)
        (lk_en && wr_en && !wr_narrow && wr_idx == 5'(LINK_IX))
        |=> regs[LINK_IX] == $past(wr_data));

    // R11
    p_reset_clears_r11: assert property (@(posedge clk)
        rst |=> regs == '0);

endmodule

bind scalar_regfile scalar_regfile_chk #(.LINK_IX(LINK_IX)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ra_idx    (ra_idx),
    .ra_sp     (ra_sp),
    .ra_data   (ra_data),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_sp     (wr_sp),
    .wr_narrow (wr_narrow),
    .wr_data   (wr_data),
    .lk_en     (lk_en),
    .lk_addr   (lk_addr),
    .regs      (regs_q)
);

// File: tb/scalar_regfile_tb.sv
module scalar_regfile_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  ra_idx = '0;
    logic        ra_sp = 1'b0;
    logic [1:0]  ra_size = '0;
    logic        ra_sext = 1'b0;
    logic [63:0] ra_data;
    logic [4:0]  rb_idx = '0;
    logic        rb_sp = 1'b0;
    logic [1:0]  rb_size = '0;
    logic        rb_sext = 1'b0;
    logic [63:0] rb_data;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_idx = '0;
    logic        wr_sp = 1'b0;
    logic        wr_narrow = 1'b0;
    logic [63:0] wr_data = '0;
    logic        lk_en = 1'b0;
    logic [63:0] lk_addr = '0;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    scalar_regfile u_dut (
        .clk(clk), .rst(rst),
        .ra_idx(ra_idx), .ra_sp(ra_sp), .ra_size(ra_size), .ra_sext(ra_sext), .ra_data(ra_data),
        .rb_idx(rb_idx), .rb_sp(rb_sp), .rb_size(rb_size), .rb_sext(rb_sext), .rb_data(rb_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_sp(wr_sp), .wr_narrow(wr_narrow), .wr_data(wr_data),
        .lk_en(lk_en), .lk_addr(lk_addr)
    );

    function automatic logic [63:0] pat(input int i);
        logic [63:0] v;
        v = 64'(i + 1) * 64'h0101_0101_0101_0101 + 64'h0000_1234_0000_0000;
        if (i % 2 == 1) v = v ^ 64'h8080_8080_8080_8080;
        return v;
    endfunction

    function automatic logic [63:0] expect_rd(input logic [63:0] v, input int sz, input bit sx);
        int w;
        logic [63:0] m;
        if (sz == 0) return v;
        w = 64 >> sz;
        m = (64'd1 << w) - 64'd1;
        if (sx && v[w-1]) return (v & m) | ~m;
        return v & m;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic write_op(input int idx, input bit sp, input bit narrow,
                            input logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 5'(idx); wr_sp = sp; wr_narrow = narrow; wr_data = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic read_a(input int idx, input bit sp, input int sz, input bit sx,
                          output logic [63:0] v);
        ra_idx = 5'(idx); ra_sp = sp; ra_size = 2'(sz); ra_sext = sx;
        #1 v = ra_data;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R11: all registers zero after reset
        for (int i = 0; i < 32; i++) begin
            read_a(i, 1'b1, 0, 1'b0, v);
            check("R11 reset value", v, 64'd0);
        end

        // R7/R3: full writes of every index, stack pointer via selector
        for (int i = 0; i < 32; i++) write_op(i, 1'b1, 1'b0, pat(i));
        @(negedge clk);
        for (int i = 0; i < 32; i++) begin
            for (int sz = 0; sz < 4; sz++) begin
                for (int sx = 0; sx < 2; sx++) begin
                    read_a(i, 1'b1, sz, sx[0], v);
                    if (i == 31)       check("R3 stack pointer read", v, expect_rd(pat(i), sz, sx[0]));
                    else if (sz == 0)  check("R7 full read", v, pat(i));
                    else if (sx == 0)  check("R5 zero-extended read", v, expect_rd(pat(i), sz, 1'b0));
                    else               check("R6 sign-extended read", v, expect_rd(pat(i), sz, 1'b1));
                end
            end
            rb_idx = 5'(31 - i); rb_sp = 1'b1; rb_size = 2'd0; rb_sext = 1'b0;
            #1 check("R7 port B full read", rb_data, pat(31 - i));
        end

        // R1: zero alias at every width while SP is nonzero
        for (int sz = 0; sz < 4; sz++) begin
            read_a(31, 1'b0, sz, 1'b1, v);
            check("R1 zero alias read", v, 64'd0);
        end

        // R2: write to zero alias is dropped
        write_op(31, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF);
        @(negedge clk);
        read_a(31, 1'b1, 0, 1'b0, v);  check("R2 SP untouched", v, pat(31));
        read_a(31, 1'b0, 0, 1'b0, v);  check("R2 zero still zero", v, 64'd0);
        read_a(30, 1'b1, 0, 1'b0, v);  check("R2 neighbour untouched", v, pat(30));

        // R4: narrow writes clear upper half
        write_op(5, 1'b0, 1'b1, 64'hFFFF_FFFF_8765_4321);
        write_op(31, 1'b1, 1'b1, 64'hDEAD_BEEF_0000_00F0);
        @(negedge clk);
        read_a(5, 1'b0, 0, 1'b0, v);   check("R4 narrow write reg5", v, 64'h0000_0000_8765_4321);
        read_a(31, 1'b1, 0, 1'b0, v);  check("R4 narrow write SP", v, 64'h0000_0000_0000_00F0);
        read_a(5, 1'b0, 1, 1'b1, v);   check("R6 word sign-extend after narrow", v, 64'hFFFF_FFFF_8765_4321);

        // R8: link save alone
        @(negedge clk);
        lk_en = 1'b1; lk_addr = 64'h0000_4000_0000_1004;
        @(posedge clk); #1 lk_en = 1'b0;
        @(negedge clk);
        read_a(30, 1'b0, 0, 1'b0, v);  check("R8 link saved", v, 64'h0000_4000_0000_1004);

        // R9: collision, ordinary write wins
        @(negedge clk);
        lk_en = 1'b1; lk_addr = 64'h1111_2222_3333_4444;
        wr_en = 1'b1; wr_idx = 5'd30; wr_sp = 1'b0; wr_narrow = 1'b0; wr_data = 64'hAAAA_5555_AAAA_5555;
        @(posedge clk); #1 lk_en = 1'b0; wr_en = 1'b0;
        @(negedge clk);
        read_a(30, 1'b0, 0, 1'b0, v);  check("R9 write beats link", v, 64'hAAAA_5555_AAAA_5555);

        // R8: link save while ordinary write goes elsewhere
        @(negedge clk);
        lk_en = 1'b1; lk_addr = 64'h0000_0000_0BAD_F00D;
        wr_en = 1'b1; wr_idx = 5'd7; wr_sp = 1'b0; wr_narrow = 1'b0; wr_data = 64'h7777_7777_7777_7777;
        @(posedge clk); #1 lk_en = 1'b0; wr_en = 1'b0;
        @(negedge clk);
        read_a(30, 1'b0, 0, 1'b0, v);  check("R8 link with other write", v, 64'h0000_0000_0BAD_F00D);
        read_a(7, 1'b0, 0, 1'b0, v);   check("R8 other write lands", v, 64'h7777_7777_7777_7777);

        // R10: no bypass, old value until the edge
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 5'd12; wr_sp = 1'b0; wr_narrow = 1'b0; wr_data = 64'h0F0F_0F0F_0F0F_0F0F;
        read_a(12, 1'b0, 0, 1'b0, v);  check("R10 old value before edge", v, pat(12));
        @(posedge clk); #1 wr_en = 1'b0;
        read_a(12, 1'b0, 0, 1'b0, v);  check("R10 new value after edge", v, 64'h0F0F_0F0F_0F0F_0F0F);

        // R11: reset mid-run
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1;
        @(negedge clk); rst = 1'b0;
        for (int i = 0; i < 32; i++) begin
            read_a(i, 1'b1, 0, 1'b0, v);
            check("R11 reset mid-run", v, 64'd0);
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule